// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide parallel flash device model with a 19-bit address and an 8-bit data path. It observes host write cycles, each marked by a one-cycle write strobe that carries an address and a data byte. It recognises the multi-cycle, address-qualified unlock sequences that guard every state-changing command. For each completed command it raises a single-cycle request toward a separate operation engine. That engine performs the program, erase and suspend work and reports back its busy, erasing, suspended and fault status.

The decoder also keeps the read mode of the device. Reads come either from the array or from the identification data. Any write that breaks a sequence sends the decoder back to idle and to array read mode, with no request issued. While the engine is busy, the decoder ignores every write except an erase suspend, and except a reset once the engine has reported a timeout fault. All requests and the read mode are registered. Each request appears in the cycle that follows the write edge that completed its command.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, all seven request outputs are low and `id_mode` is 0 (array read).
- R2: The write sequence AAh@555h, 55h@2AAh, A0h@555h, followed by a fourth write at any address with any data, raises `req_program` for one cycle after the fourth write edge. `req_addr` and `req_data` carry that fourth write's address and data. A fourth-cycle data value of F0h is programmed like any other value.
- R3: The write sequence AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h raises `req_chip_erase` for one cycle.
- R4: The same five-write prefix as R3, followed by 30h at any address, raises `req_sector_erase`. `req_sector` equals bits 18..16 of that sixth write's address.
- R5: AAh@555h, 55h@2AAh, 90h@555h raises `req_id` and sets `id_mode` to 1. `id_mode` stays 1 until a reset command, a completed command or a mismatching write.
- R6: While the engine is idle, F0h written at any address, at any sequence step other than the fourth program cycle, raises `req_reset`, clears `id_mode` and returns the sequence to its first step.
- R7: A write whose data or address does not match the expected step raises no request. It returns the sequence to the first step and clears `id_mode`. The following write is then decoded as a first cycle.
- R8: Only address bits 10..0 are compared against 555h and 2AAh. The upper address bits do not matter for unlock and command cycles.
- R9: While `eng_busy` is 1, writes raise no program, chip erase, sector erase, ID or resume request, and they do not advance the sequence.
- R10: B0h at any address while `eng_busy` and `eng_erasing` are both 1 raises `req_suspend`. B0h at any other time raises no request.
- R11: F0h while `eng_busy` is 1 raises `req_reset` only if `eng_fault` is 1.
- R12: 30h at any address, at the first sequence step, while the engine is idle and `eng_suspended` is 1, raises `req_resume`. Without `eng_suspended`, the same write is a mismatch.
- R13: At most one request is high in any cycle, and a request is high only in the cycle after a write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle host write strobe |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data |
| eng_busy | input | 1 | Operation engine is running an embedded operation |
| eng_erasing | input | 1 | A sector erase is running and can be suspended |
| eng_suspended | input | 1 | A sector erase is suspended |
| eng_fault | input | 1 | Engine reports a timeout fault |
| req_reset | output | 1 | Return-to-array-read request |
| req_program | output | 1 | Program-byte request |
| req_chip_erase | output | 1 | Whole-device erase request |
| req_sector_erase | output | 1 | Sector erase request |
| req_suspend | output | 1 | Erase suspend request |
| req_resume | output | 1 | Erase resume request |
| req_id | output | 1 | Identification read request |
| req_addr | output | 19 | Captured program address |
| req_data | output | 8 | Captured program data |
| req_sector | output | 3 | Captured sector number for sector erase |
| id_mode | output | 1 | 1 = identification read mode, 0 = array read |

## Verification
The embedded assertions check several rules on every cycle. A request never appears without a write in the previous cycle. A busy engine never receives a program, erase, ID or resume request. Suspend and resume requests appear only under the engine status that permits them. The read mode always agrees with the last ID or reset request. Only the bench scenarios can show that each full unlock sequence maps to the correct request with the right captured address, data or sector. Those scenarios also show that a broken sequence restarts cleanly, that the high address bits are ignored, and that F0h in the program data cycle is programmed rather than treated as a reset.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PROG, SQ_ERS1, SQ_ERS2, SQ_ERS3
  } seq_t;

  // request kinds; index i+1 maps to request output bit i
  typedef enum logic [2:0] {
    RQ_NONE, RQ_RESET, RQ_PROGRAM, RQ_CHIP, RQ_SECTOR, RQ_SUSPEND, RQ_RESUME, RQ_ID
  } req_t;

  localparam int NUM_REQ = 7;

  localparam logic [7:0] CMD_UNLOCK1 = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK2 = 8'h55;
  localparam logic [7:0] CMD_PROGRAM = 8'hA0;
  localparam logic [7:0] CMD_ERASE   = 8'h80;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_SECTOR  = 8'h30;
  localparam logic [7:0] CMD_RESUME  = 8'h30;
  localparam logic [7:0] CMD_RESET   = 8'hF0;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_IDREAD  = 8'h90;

  typedef struct packed {
    logic at_a;    // unlock address A
    logic at_b;    // unlock address B
    logic is_un1;
    logic is_un2;
    logic is_prog;
    logic is_ers;
    logic is_chip;
    logic is_sect;
    logic is_res;
    logic is_rst;
    logic is_susp;
    logic is_id;
  } cyc_flags_t;
endpackage

// File: rtl/fcd_cycle_class.sv
module fcd_cycle_class
  import fcd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CMP_W  = 11,
  parameter logic [CMP_W-1:0] UNL_A = 11'h555,
  parameter logic [CMP_W-1:0] UNL_B = 11'h2AA
) (
  input  logic [CMP_W-1:0]  addr_lo,
  input  logic [DATA_W-1:0] data,
  output cyc_flags_t        flags
);
  always_comb begin
    flags.at_a    = (addr_lo == UNL_A);
    flags.at_b    = (addr_lo == UNL_B);
    flags.is_un1  = (data == DATA_W'(CMD_UNLOCK1));
    flags.is_un2  = (data == DATA_W'(CMD_UNLOCK2));
    flags.is_prog = (data == DATA_W'(CMD_PROGRAM));
    flags.is_ers  = (data == DATA_W'(CMD_ERASE));
    flags.is_chip = (data == DATA_W'(CMD_CHIP));
    flags.is_sect = (data == DATA_W'(CMD_SECTOR));
    flags.is_res  = (data == DATA_W'(CMD_RESUME));
    flags.is_rst  = (data == DATA_W'(CMD_RESET));
    flags.is_susp = (data == DATA_W'(CMD_SUSPEND));
    flags.is_id   = (data == DATA_W'(CMD_IDREAD));
  end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  cyc_flags_t f,
  input  logic       eng_busy,
  input  logic       eng_erasing,
  input  logic       eng_suspended,
  input  logic       eng_fault,
  output req_t       kind,
  output logic       id_mode
);
  seq_t st_q, st_n;
  logic id_n;

  always_comb begin
    st_n = st_q;
    id_n = id_mode;
    kind = RQ_NONE;
    if (wr_en) begin
      if (eng_busy) begin
        if (eng_fault && f.is_rst) begin
          kind = RQ_RESET;
          st_n = SQ_IDLE;
          id_n = 1'b0;
        end else if (eng_erasing && f.is_susp) begin
          kind = RQ_SUSPEND;
        end
      end else if (st_q != SQ_PROG && f.is_rst) begin
        kind = RQ_RESET;
        st_n = SQ_IDLE;
        id_n = 1'b0;
      end else begin
        st_n = SQ_IDLE;
        unique case (st_q)
          SQ_IDLE: begin
            if (f.at_a && f.is_un1) st_n = SQ_UNL1;
            else if (eng_suspended && f.is_res) kind = RQ_RESUME;
            else id_n = 1'b0;
          end
          SQ_UNL1: begin
            if (f.at_b && f.is_un2) st_n = SQ_UNL2;
            else id_n = 1'b0;
          end
          SQ_UNL2: begin
            if (f.at_a && f.is_prog) st_n = SQ_PROG;
            else if (f.at_a && f.is_ers) st_n = SQ_ERS1;
            else if (f.at_a && f.is_id) begin
              kind = RQ_ID;
              id_n = 1'b1;
            end else id_n = 1'b0;
          end
          SQ_PROG: begin
            kind = RQ_PROGRAM;
            id_n = 1'b0;
          end
          SQ_ERS1: begin
            if (f.at_a && f.is_un1) st_n = SQ_ERS2;
            else id_n = 1'b0;
          end
          SQ_ERS2: begin
            if (f.at_b && f.is_un2) st_n = SQ_ERS3;
            else id_n = 1'b0;
          end
          SQ_ERS3: begin
            id_n = 1'b0;
            if (f.at_a && f.is_chip) kind = RQ_CHIP;
            else if (f.is_sect) kind = RQ_SECTOR;
          end
          default: id_n = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SQ_IDLE;
      id_mode <= 1'b0;
    end else begin
      st_q    <= st_n;
      id_mode <= id_n;
    end
  end

  // a busy engine holds the sequence where it was
  AST_BUSY_HOLDS_SEQ: assert property (@(posedge clk) disable iff (rst)
    ($past(eng_busy) && !$past(eng_fault)) |-> $stable(st_q)); // R9
endmodule

// File: rtl/fcd_req_out.sv
module fcd_req_out
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  req_t              kind,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_REQ-1:0] req_vec,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [SECT_W-1:0] req_sector
);
  localparam int SECT_LSB = ADDR_W - SECT_W;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
    always_ff @(posedge clk) begin
      if (rst) req_vec[i] <= 1'b0;
      else     req_vec[i] <= (kind == req_t'(i + 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_addr   <= '0;
      req_data   <= '0;
      req_sector <= '0;
    end else begin
      if (kind == RQ_PROGRAM) begin
        req_addr <= wr_addr;
        req_data <= wr_data;
      end
      if (kind == RQ_SECTOR) req_sector <= wr_addr[ADDR_W-1:SECT_LSB];
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int CMP_W  = 11,
  parameter int SECT_W = 3,
  parameter logic [CMP_W-1:0] UNL_A = 11'h555,
  parameter logic [CMP_W-1:0] UNL_B = 11'h2AA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              eng_busy,
  input  logic              eng_erasing,
  input  logic              eng_suspended,
  input  logic              eng_fault,
  output logic              req_reset,
  output logic              req_program,
  output logic              req_chip_erase,
  output logic              req_sector_erase,
  output logic              req_suspend,
  output logic              req_resume,
  output logic              req_id,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [SECT_W-1:0] req_sector,
  output logic              id_mode
);
  cyc_flags_t         flags;
  req_t               kind;
  logic [NUM_REQ-1:0] req_vec;

  fcd_cycle_class #(.DATA_W(DATA_W), .CMP_W(CMP_W), .UNL_A(UNL_A), .UNL_B(UNL_B)) u_class (
    .addr_lo (wr_addr[CMP_W-1:0]),
    .data    (wr_data),
    .flags   (flags)
  );

  fcd_seq_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .f             (flags),
    .eng_busy      (eng_busy),
    .eng_erasing   (eng_erasing),
    .eng_suspended (eng_suspended),
    .eng_fault     (eng_fault),
    .kind          (kind),
    .id_mode       (id_mode)
  );

  fcd_req_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .kind       (kind),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .req_vec    (req_vec),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .req_sector (req_sector)
  );

  assign req_reset        = req_vec[0];
  assign req_program      = req_vec[1];
  assign req_chip_erase   = req_vec[2];
  assign req_sector_erase = req_vec[3];
  assign req_suspend      = req_vec[4];
  assign req_resume       = req_vec[5];
  assign req_id           = req_vec[6];

  AST_REQ_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (|req_vec) |-> $past(wr_en)); // R13
  AST_BUSY_BLOCKS_CMDS: assert property (@(posedge clk) disable iff (rst)
    $past(eng_busy) |-> !(req_program || req_chip_erase || req_sector_erase || req_id || req_resume)); // R9
  AST_SUSPEND_GATED: assert property (@(posedge clk) disable iff (rst)
    req_suspend |-> $past(eng_busy && eng_erasing)); // R10
  AST_RESUME_GATED: assert property (@(posedge clk) disable iff (rst)
    req_resume |-> $past(eng_suspended && !eng_busy)); // R12
  AST_ID_SETS_MODE: assert property (@(posedge clk) disable iff (rst)
    req_id |-> id_mode); // R5
  AST_RESET_CLEARS_MODE: assert property (@(posedge clk) disable iff (rst)
    req_reset |-> !id_mode); // R6
  AST_BUSY_RESET_FAULT: assert property (@(posedge clk) disable iff (rst)
    (req_reset && $past(eng_busy)) |-> $past(eng_fault)); // R11
endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
  localparam int K_NONE = 0, K_RST = 1, K_PROG = 2, K_CHIP = 3, K_SECT = 4,
                 K_SUSP = 5, K_RES = 6, K_ID = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic eng_busy = 1'b0, eng_erasing = 1'b0, eng_suspended = 1'b0, eng_fault = 1'b0;
  logic req_reset, req_program, req_chip_erase, req_sector_erase;
  logic req_suspend, req_resume, req_id, id_mode;
  logic [18:0] req_addr;
  logic [7:0]  req_data;
  logic [2:0]  req_sector;

  int n_chk = 0;
  int n_bad = 0;
  logic wr_seen = 1'b0;
  bit done = 1'b0;

  int          q_kind[$];
  logic [18:0] q_addr[$];
  logic [7:0]  q_data[$];
  bit          q_idm[$];
  string       q_tag[$];

  always #10 clk = ~clk;   // 50 MHz

  flash_cmd_decoder dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .eng_busy(eng_busy), .eng_erasing(eng_erasing), .eng_suspended(eng_suspended),
    .eng_fault(eng_fault), .req_reset(req_reset), .req_program(req_program),
    .req_chip_erase(req_chip_erase), .req_sector_erase(req_sector_erase),
    .req_suspend(req_suspend), .req_resume(req_resume), .req_id(req_id),
    .req_addr(req_addr), .req_data(req_data), .req_sector(req_sector), .id_mode(id_mode)
  );

  function automatic int actual_kind();
    logic [6:0] v;
    v = {req_id, req_resume, req_suspend, req_sector_erase, req_chip_erase, req_program, req_reset};
    if ($countones(v) > 1) return 99;
    for (int i = 0; i < 7; i++) if (v[i]) return i + 1;
    return K_NONE;
  endfunction

  // driver: one write, expectation pushed into the scoreboard
  task automatic wr(input logic [18:0] a, input logic [7:0] d, input int k,
                    input bit idm, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    q_kind.push_back(k); q_addr.push_back(a); q_data.push_back(d);
    q_idm.push_back(idm); q_tag.push_back(tag);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  always @(posedge clk) wr_seen <= wr_en;

  // monitor: compare the cycle after each write edge
  always @(negedge clk) begin
    if (wr_seen && q_kind.size() > 0) begin
      int k; logic [18:0] a; logic [7:0] d; bit idm; string tag; int act;
      k = q_kind.pop_front(); a = q_addr.pop_front(); d = q_data.pop_front();
      idm = q_idm.pop_front(); tag = q_tag.pop_front();
      act = actual_kind();
      n_chk++;
      if (act != k || id_mode != idm) begin
        n_bad++;
        $display("FAIL %s: request kind %0d id_mode %0b, expected kind %0d id_mode %0b",
                 tag, act, id_mode, k, idm);
      end else if (k == K_PROG && (req_addr != a || req_data != d)) begin
        n_bad++;
        $display("FAIL %s: program addr %h data %h, expected addr %h data %h",
                 tag, req_addr, req_data, a, d);
      end else if (k == K_SECT && req_sector != a[18:16]) begin
        n_bad++;
        $display("FAIL %s: sector %0d, expected %0d", tag, req_sector, a[18:16]);
      end
    end else if (!wr_seen && actual_kind() != K_NONE) begin
      n_chk++; n_bad++;
      $display("FAIL R13: request kind %0d without a write, expected 0", actual_kind());
    end
  end

  task automatic unlock(input bit idm, input string tag);
    wr(19'h00555, 8'hAA, K_NONE, idm, tag);
    wr(19'h002AA, 8'h55, K_NONE, idm, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (actual_kind() != K_NONE || id_mode != 1'b0) begin
      n_bad++;
      $display("FAIL R1: kind %0d id_mode %0b, expected 0 0", actual_kind(), id_mode);
    end

    // R2 program, R8 upper bits on unlock addresses ignored
    wr(19'h7F555, 8'hAA, K_NONE, 0, "R8 unlock1");
    wr(19'h3A2AA, 8'h55, K_NONE, 0, "R8 unlock2");
    wr(19'h12555, 8'hA0, K_NONE, 0, "R2 setup");
    wr(19'h41234, 8'h5A, K_PROG, 0, "R2 program");
    // R2 F0h as program data
    unlock(0, "R2 unlock");
    wr(19'h00555, 8'hA0, K_NONE, 0, "R2 setup");
    wr(19'h60007, 8'hF0, K_PROG, 0, "R2 program F0 data");
    // R3 chip erase
    unlock(0, "R3 unlock");
    wr(19'h00555, 8'h80, K_NONE, 0, "R3 erase setup");
    unlock(0, "R3 unlock again");
    wr(19'h00555, 8'h10, K_CHIP, 0, "R3 chip erase");
    // R4 sector erase
    unlock(0, "R4 unlock");
    wr(19'h00555, 8'h80, K_NONE, 0, "R4 erase setup");
    unlock(0, "R4 unlock again");
    wr(19'h5ABCD, 8'h30, K_SECT, 0, "R4 sector erase");
    // R5 ID mode, R6 reset clears it
    unlock(0, "R5 unlock");
    wr(19'h00555, 8'h90, K_ID, 1, "R5 id read");
    wr(19'h00000, 8'hF0, K_RST, 0, "R6 reset leaves id");
    // R6 reset mid-sequence
    wr(19'h00555, 8'hAA, K_NONE, 0, "R6 unlock1");
    wr(19'h1FFFF, 8'hF0, K_RST, 0, "R6 reset mid sequence");
    wr(19'h41234, 8'h5A, K_NONE, 0, "R6 sequence restarted");
    // R7 mismatches
    wr(19'h00555, 8'hAA, K_NONE, 0, "R7 unlock1");
    wr(19'h002AA, 8'h56, K_NONE, 0, "R7 wrong data");
    wr(19'h00555, 8'hA0, K_NONE, 0, "R7 restart from first step");
    wr(19'h00555, 8'hAA, K_NONE, 0, "R7 unlock1");
    wr(19'h002AB, 8'h55, K_NONE, 0, "R7 wrong address");
    unlock(0, "R7 unlock");
    wr(19'h00555, 8'h90, K_ID, 1, "R7 id read");
    wr(19'h00000, 8'h12, K_NONE, 0, "R7 mismatch clears id mode");
    // R10 B0h ignored when idle
    wr(19'h00000, 8'hB0, K_NONE, 0, "R10 suspend while idle");
    // R9 busy blocks, R10 suspend, R11 fault reset
    eng_busy = 1'b1; eng_erasing = 1'b1;
    unlock(0, "R9 unlock while busy");
    wr(19'h00555, 8'hA0, K_NONE, 0, "R9 setup while busy");
    wr(19'h01000, 8'h77, K_NONE, 0, "R9 program while busy");
    wr(19'h33333, 8'hB0, K_SUSP, 0, "R10 suspend");
    wr(19'h00000, 8'hF0, K_NONE, 0, "R11 reset without fault");
    eng_fault = 1'b1;
    wr(19'h00000, 8'hF0, K_RST, 0, "R11 reset with fault");
    eng_erasing = 1'b0;
    wr(19'h33333, 8'hB0, K_NONE, 0, "R10 suspend when not erasing");
    eng_fault = 1'b0; eng_busy = 1'b0;
    // R9 sequence not advanced while busy: A0h@555 now at first step
    wr(19'h00555, 8'hA0, K_NONE, 0, "R9 no sequence carried");
    // R12 resume
    wr(19'h2ABCD, 8'h30, K_NONE, 0, "R12 resume not suspended");
    eng_suspended = 1'b1;
    wr(19'h2ABCD, 8'h30, K_RES, 0, "R12 resume");
    // R2 program while suspended still decodes
    unlock(0, "R2 unlock during suspend");
    wr(19'h00555, 8'hA0, K_NONE, 0, "R2 setup during suspend");
    wr(19'h7FFFF, 8'h01, K_PROG, 0, "R2 program during suspend");
    eng_suspended = 1'b0;

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule